// File: doc/BRIEF.md
# MDIO Management Master with Extended-Register Remap

This block drives a clause-22 MDIO management bus on behalf of a host that configures an Ethernet switch. The host hands over one request at a time: a direction (read or write), a 5-bit PHY address, an 8-bit register index and, for writes, 16 bits of data. The block builds the serial frame, generates MDC from the system clock through a programmable divider, shifts the frame out on MDIO and, for reads, releases the line and collects the returned bits. When the frame ends it returns a one-cycle response carrying the read data and a no-response flag.

PHY address zero is never used as a real device address on this bus, so the block treats it as an escape into the switch's wider 8-bit register space. Such a request still goes out as an ordinary read or write frame, with the same opcodes. The register index is spread over the PHY and register fields of that frame, so a standard clause-22 controller path reaches the extended registers. A valid extended read returns an upper data byte of zero. A bus nobody drives reads as all ones through its pull-up, and the block flags that pattern.

The request side is valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the response cycle, and any `req_valid` asserted during that window is dropped, not queued. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle and the host must capture `rsp_rdata` and `rsp_noresp` in that cycle.

Top module: `mdio_smi_master`

## Requirements
- R1: After reset `mdc` is low, `mdio_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: Each frame is 64 MDC periods, sent MSB first: 32 ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY field, 5-bit register field, 2 turnaround bits, 16 data bits.
- R3: With `req_phy` nonzero, the PHY field equals `req_phy`, the register field equals `req_reg[4:0]`, and `req_reg[7:5]` has no effect on the frame.
- R4: With `req_phy` zero, the PHY field is {`req_reg[7]`, `req_reg[6]`, 1, 1, `req_reg[5]`} (MSB first), the register field is `req_reg[4:0]`, and the opcode is the normal read or write code.
- R5: On a write `mdio_oe` is high for all 64 bits and the turnaround is `10`. On a read `mdio_oe` is high for frame bits 0 to 45 and low from bit 46 (first turnaround bit) to bit 63.
- R6: On a read, `mdio_i` is sampled at the rising edge of MDC in frame bits 48 to 63. The first sample is bit 15 of `rsp_rdata`. The value is valid in the single cycle `rsp_valid` is high. After a write, `rsp_rdata` is zero.
- R7: `rsp_noresp` is high with `rsp_valid` exactly when a read returned 16'hFFFF. It is low for every other read and for writes.
- R8: MDC high and low phases each last max(`cfg_div`,1) system cycles. MDC is low whenever no frame is in flight. `mdio_o` changes only while MDC is low.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after `rsp_valid`. A `req_valid` during that window starts no frame. `rsp_valid` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | MDC half period in system cycles (0 is treated as 1) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address; 0 selects extended access |
| req_reg | input | 8 | Register index (bits 7:5 used only for extended access) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| rsp_noresp | output | 1 | Read returned all ones |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench sweeps all 256 extended register indices as writes, with data derived from the index. This separates every remapped bit of the PHY and register fields from its neighbours. A pass over all 31 normal PHY addresses, with junk in the upper index bits, checks that those bits stay out of normal frames. Reads over both address kinds return index-dependent data from a bench target that drives MDIO after each falling edge. Floating-bus reads show the no-response flag apart from valid data. Divider settings of 0 to 3 check the MDC phase lengths, and a request offered mid-frame checks that it is dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int XREG_W     = 8;
  localparam int DATA_W     = 16;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam logic [1:0] TA_RD    = 2'b11;

  typedef struct packed {
    logic              wr;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regf;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
    logic [FRAME_LEN-1:0] f;
    f = {{PRE_LEN{1'b1}}, SOF_CODE, (c.wr ? OP_WR : OP_RD), c.phy, c.regf,
         (c.wr ? TA_WR : TA_RD), (c.wr ? c.data : {DATA_W{1'b1}})};
    return f;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  assign lim       = (half_div == '0) ? '0 : half_div - 1'b1;
  assign wrap      = run && (cnt >= lim);
  assign tick_rise = wrap && !mdc;
  assign tick_fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_MDC_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(mdc)) |-> $past(wrap)); // R8
endmodule

// File: rtl/mdio_addr_map.sv
module mdio_addr_map
  import mdio_pkg::*;
(
  input  logic              wr,
  input  logic [PHY_W-1:0]  phy_in,
  input  logic [XREG_W-1:0] reg_in,
  input  logic [DATA_W-1:0] wdata,
  output mdio_cmd_t         cmd
);
  logic ext;
  assign ext = (phy_in == '0);

  always_comb begin
    cmd.wr   = wr;
    cmd.data = wdata;
    cmd.regf = reg_in[REG_W-1:0];
    if (ext) cmd.phy = {reg_in[7], reg_in[6], 1'b1, 1'b1, reg_in[5]};
    else     cmd.phy = phy_in;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              mdc,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              noresp
);
  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic [IDX_W-1:0]     nxt_idx;
  logic                 is_wr;
  logic [DATA_W-1:0]    rx_sh;
  logic                 last_bit;

  assign nxt_idx  = bit_idx + 1'b1;
  assign last_bit = (bit_idx == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
      is_wr   <= 1'b0;
      rx_sh   <= '0;
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      noresp  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          shreg   <= build_frame(cmd);
          mdio_o  <= build_frame(cmd)[FRAME_LEN-1];
          mdio_oe <= 1'b1;
          bit_idx <= '0;
          is_wr   <= cmd.wr;
          rx_sh   <= '0;
          busy    <= 1'b1;
        end
      end else begin
        if (tick_rise && !is_wr && (bit_idx >= IDX_W'(DATA_BIT)))
          rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
        if (tick_fall) begin
          if (last_bit) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            done    <= 1'b1;
            rdata   <= is_wr ? '0 : rx_sh;
            noresp  <= !is_wr && (rx_sh == {DATA_W{1'b1}});
          end else begin
            bit_idx <= nxt_idx;
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
            mdio_o  <= shreg[FRAME_LEN-2];
            mdio_oe <= is_wr || (nxt_idx < IDX_W'(TA_BIT));
          end
        end
      end
    end
  end

  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc); // R8

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_wr && (bit_idx >= IDX_W'(TA_BIT))) |-> !mdio_oe); // R5

  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_wr && !start) |-> mdio_oe); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/mdio_smi_master.sv
module mdio_smi_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [4:0]        req_phy,
  input  logic [7:0]        req_reg,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_noresp,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_cmd_t cmd;
  logic      busy;
  logic      start;
  logic      tick_rise;
  logic      tick_fall;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  mdio_addr_map u_map (
    .wr     (req_write),
    .phy_in (req_phy),
    .reg_in (req_reg),
    .wdata  (req_wdata),
    .cmd    (cmd)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .half_div  (cfg_div),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall)
  );

  mdio_frame_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd       (cmd),
    .mdc       (mdc),
    .tick_rise (tick_rise),
    .tick_fall (tick_fall),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (rsp_valid),
    .rdata     (rsp_rdata),
    .noresp    (rsp_noresp)
  );

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mdc); // R8

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready); // R9

  AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R9

  AST_NORESP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_noresp) |-> (rsp_rdata == 16'hFFFF)); // R7
endmodule

// File: tb/mdio_smi_master_tb.sv
module mdio_smi_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [7:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_noresp;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  mdio_smi_master #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_noresp(rsp_noresp),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = !clk;

  // bench-side bus observer and target
  logic [63:0] cap = '0;
  logic [63:0] capoe = '0;
  int          pidx = 0;
  int          base = 0;
  logic        tgt_on = 1'b0;
  logic [15:0] tgt_val = '0;
  time         t_rise = 0;
  time         hi_len = 0;

  always @(posedge mdc) begin
    cap    <= {cap[62:0], mdio_o};
    capoe  <= {capoe[62:0], mdio_oe};
    pidx   <= pidx + 1;
    t_rise = $time;
  end

  always @(negedge mdc) hi_len = $time - t_rise;

  initial mdio_i = 1'b1;
  always @(negedge mdc) begin
    int n;
    n = pidx - base;
    if (tgt_on && n >= 48 && n <= 63) mdio_i = tgt_val[63 - n];
    else mdio_i = 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_bad = n_bad + 1;
      n_cmp = n_cmp + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] fields(input logic [4:0] phy, input logic [7:0] idx);
    if (phy == 5'd0) return {idx[7:6], 2'b11, idx[5], idx[4:0]};
    else             return {phy, idx[4:0]};
  endfunction

  task automatic run_req(input logic wr, input logic [4:0] phy, input logic [7:0] idx,
                         input logic [15:0] wd, input logic respond, input logic [15:0] tv,
                         input int div);
    logic [63:0] ef;
    logic [63:0] eoe;
    logic [15:0] er;
    int          w;
    cfg_div = 8'(div);
    base    = pidx;
    tgt_on  = respond;
    tgt_val = tv;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = idx; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!rsp_valid && w < 20000) begin
      @(negedge clk);
      w = w + 1;
    end
    ef  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), fields(phy, idx),
           (wr ? {2'b10, wd} : 18'h0)};
    eoe = wr ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    if (phy == 5'd0) check("R4 extended frame", wr ? cap : (cap & eoe), ef);
    else             check("R3 normal frame",   wr ? cap : (cap & eoe), ef);
    check("R2 frame length", 64'(pidx - base), 64'd64);
    check("R5 output enable", capoe, eoe);
    er = wr ? 16'h0 : (respond ? tv : 16'hFFFF);
    check("R6 read data", {48'h0, rsp_rdata}, {48'h0, er});
    check("R7 no-response flag", {63'h0, rsp_noresp}, {63'h0, (!wr && er == 16'hFFFF)});
    check("R8 mdc high phase", 64'(hi_len), 64'((div == 0 ? 1 : div) * 8));
    @(negedge clk);
    check("R9 single pulse and ready", {62'h0, rsp_valid, req_ready}, 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {60'h0, mdc, mdio_oe, req_ready, rsp_valid}, 64'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {60'h0, mdc, mdio_oe, req_ready, rsp_valid}, 64'h2);

    // R4: all extended indices as writes
    for (int i = 0; i < 256; i++)
      run_req(1'b1, 5'd0, 8'(i), {8'(i), ~8'(i)}, 1'b0, 16'h0, 1);

    // R3: every normal PHY, junk in index bits 7:5
    for (int p = 1; p < 32; p++)
      run_req(1'b1, 5'(p), {3'(p * 3 + 1), 5'(p ^ 5'h0A)}, 16'(p * 16'h1357), 1'b0, 16'h0, 2);

    // R6: extended reads with zero upper byte
    for (int i = 0; i < 256; i += 17)
      run_req(1'b0, 5'd0, 8'(i), 16'h0, 1'b1, {8'h00, 8'(i) ^ 8'h5A}, 3);

    // R6: normal reads
    for (int p = 1; p < 32; p++)
      run_req(1'b0, 5'(p), 8'(p * 7), 16'h0, 1'b1, 16'(p * 16'h0805), 0);

    // R7: floating bus on both access kinds
    run_req(1'b0, 5'd0, 8'h42, 16'h0, 1'b0, 16'h0, 2);
    run_req(1'b0, 5'd5, 8'h11, 16'h0, 1'b0, 16'h0, 1);

    // R9: a request offered mid-frame is dropped
    begin
      int mid;
      cfg_div = 8'd1;
      base = pidx;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd3; req_reg = 8'h04; req_wdata = 16'hA5A5;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      check("R9 busy during frame", {63'h0, req_ready}, 64'h0);
      req_valid = 1'b1; req_phy = 5'd9; req_reg = 8'h1F; req_wdata = 16'h0F0F;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      mid = pidx - base;
      repeat (300) @(negedge clk);
      check("R9 dropped request starts no frame", 64'(pidx - base), 64'(mid));
      check("R9 frame kept first request",
            cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'hA5A5});
      check("R8 mdc idle low", {63'h0, mdc}, 64'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule